// File: doc/BRIEF.md
# Texture Address and Filter Unit

This block turns one 2D texture coordinate into texel memory reads and a filtered result. A request carries an unsigned 8.8 fixed-point coordinate pair in texel units (texel centres sit at integer + 0.5), a boundary mode for each axis, a filter select, a texel width select and the texture base address. The unit resolves every needed texel index through the boundary mode of its axis, so an index such as -1 or one past the edge never faults. It then turns the index pair into a Z-order (Morton) address and reads the texels one per cycle from a synchronous memory with one cycle of read latency.

In bilinear mode the unit reads the four texels around the coordinate and blends them with 8-bit weights. In point mode it reads the single nearest texel. Stored texels are unsigned 8-bit values (in bits 7:0 of the read word) or 16-bit values. Both are returned as 16-bit unsigned normalized numbers, where 0x0000 means 0.0 and 0xFFFF means 1.0. The unit takes one request at a time. It is controlled by a five-state machine:
- ST_IDLE: ready, and it accepts a request.
- ST_READ: issues the reads.
- ST_WAIT: the last read data arrives.
- ST_ROW: the horizontal blend.
- ST_COL: the vertical blend.

The transitions are:
- IDLE→READ when a request is accepted.
- READ→WAIT after the last tap.
- WAIT→ROW, ROW→COL and COL→IDLE, each unconditional.

Top module: `tex_filter_unit`

## Requirements
- R1: Boundary mode 0 (clamp) maps an index below 0 to 0 and an index of N or more to N-1, where N is that axis's power-of-two size. Each axis uses its own mode.
- R2: Boundary mode 1 (wrap) maps an index to the index modulo N. Each axis uses its own mode.
- R3: Boundary mode 2 (mirror) reflects the index with period 2N. The index N maps to N-1 and the index -1 maps to 0. Each axis uses its own mode.
- R4: The read address is the base plus the interleave of the resolved 8-bit indices. The x bit i goes to address bit 2i and the y bit i goes to address bit 2i+1. The sum wraps at the address width.
- R5: Bilinear mode issues exactly four reads on consecutive cycles, in the order (x0,y0), (x1,y0), (x0,y1), (x1,y1). Here x0 = floor(u - 0.5), x1 = x0 + 1, and y0 and y1 are defined the same way.
- R6: Point mode issues exactly one read, at index (floor(u), floor(v)) after boundary resolution. It returns that texel unblended.
- R7: The bilinear result uses the weights fx = frac(u - 0.5) and fy = frac(v - 0.5), each an 8-bit value. The result is ((A(256-fx)+B·fx)(256-fy) + (C(256-fx)+D·fx)·fy) >> 16, where A, B, C and D are the taps in R5 order.
- R8: When the width select is 0, a texel byte b becomes b·257. When the width select is 1, the 16-bit word is used unchanged.
- R9: res_valid is a one-cycle pulse. It rises three cycles after the cycle in which the last read data returns, which is four cycles after that read is issued.
- R10: After reset, req_ready is 1 and both mem_rd_en and res_valid are 0. req_ready is 1 only in ST_IDLE, and no read is issued while it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request |
| req_u | input | 16 | x coordinate, unsigned 8.8 |
| req_v | input | 16 | y coordinate, unsigned 8.8 |
| req_mode_x | input | 2 | x boundary mode: 0 clamp, 1 wrap, 2 mirror |
| req_mode_y | input | 2 | y boundary mode: 0 clamp, 1 wrap, 2 mirror |
| req_bilinear | input | 1 | 1 selects bilinear, 0 selects point |
| req_wide | input | 1 | 1 selects 16-bit texels, 0 selects 8-bit texels |
| req_base | input | ADDR_W | Texture base address |
| mem_rd_en | output | 1 | Texel read strobe |
| mem_addr | output | ADDR_W | Texel read address |
| mem_rd_data | input | 16 | Read data, one cycle after the strobe |
| res_valid | output | 1 | Result pulse |
| res_data | output | 16 | Normalized filtered result |

## Verification
A wrong boundary fold or interleave shows on mem_addr in the same cycle the read is issued, well before any result. A wrong tap counter or state sequence shows as a wrong number or order of strobes, or as res_valid arriving off the fourth cycle after the last strobe. A bad weight or a bad conversion appears only on res_data at the result pulse. The bench predicts each of these from integer arithmetic for every request of a dense sweep of coordinates, modes and formats on a non-square 8×4 texture.

// File: rtl/tex_pkg.sv
package tex_pkg;
    localparam int COORD_W = 10;
    localparam int TEXEL_W = 16;
    localparam int WGT_W   = 8;

    typedef enum logic [1:0] {
        BND_CLAMP  = 2'd0,
        BND_WRAP   = 2'd1,
        BND_MIRROR = 2'd2
    } bnd_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WAIT,
        ST_ROW,
        ST_COL
    } fsm_e;
endpackage

// File: rtl/tex_bound.sv
module tex_bound #(
    parameter int LOG_N = 8,
    parameter int CW    = 10
) (
    input  logic signed [CW-1:0] coord,
    input  logic [1:0]           mode,
    output logic [7:0]           idx
);
    import tex_pkg::*;
    localparam int N = 1 << LOG_N;

    logic [LOG_N:0]   period;
    logic [LOG_N-1:0] folded;

    always_comb begin
        period = coord[LOG_N:0];
        folded = period[LOG_N] ? ~period[LOG_N-1:0] : period[LOG_N-1:0];
        idx    = '0;
        case (bnd_mode_e'(mode))
            BND_WRAP:   idx[LOG_N-1:0] = coord[LOG_N-1:0];
            BND_MIRROR: idx[LOG_N-1:0] = folded;
            default: begin
                if (coord[CW-1])
                    idx = '0;
                else if (coord[CW-2:0] >= (CW-1)'(N))
                    idx = 8'(N - 1);
                else
                    idx[LOG_N-1:0] = coord[LOG_N-1:0];
            end
        endcase
    end
endmodule

// File: rtl/tex_morton.sv
module tex_morton #(
    parameter int IDX_W = 8
) (
    input  logic [IDX_W-1:0]   xi,
    input  logic [IDX_W-1:0]   yi,
    output logic [2*IDX_W-1:0] code
);
    for (genvar b = 0; b < IDX_W; b++) begin : g_bit
        assign code[2*b]   = xi[b];
        assign code[2*b+1] = yi[b];
    end
endmodule

// File: rtl/tex_blend.sv
module tex_blend #(
    parameter int TW = 16,
    parameter int WW = 8
) (
    input  logic          clk,
    input  logic          en_row,
    input  logic          en_col,
    input  logic [TW-1:0] t00,
    input  logic [TW-1:0] t10,
    input  logic [TW-1:0] t01,
    input  logic [TW-1:0] t11,
    input  logic [WW-1:0] wx,
    input  logic [WW-1:0] wy,
    output logic [TW-1:0] result
);
    localparam int RW = TW + WW + 1;
    localparam int SW = TW + 2*WW + 1;
    localparam logic [WW:0] ONE = (WW+1)'(1) << WW;

    logic [RW-1:0] top_d, bot_d, top_q, bot_q;
    logic [SW-1:0] sum_d;

    always_comb begin
        top_d = RW'(t00) * RW'(ONE - {1'b0, wx}) + RW'(t10) * RW'(wx);
        bot_d = RW'(t01) * RW'(ONE - {1'b0, wx}) + RW'(t11) * RW'(wx);
        sum_d = SW'(top_q) * SW'(ONE - {1'b0, wy}) + SW'(bot_q) * SW'(wy);
    end

    always_ff @(posedge clk) begin
        if (en_row) begin
            top_q <= top_d;
            bot_q <= bot_d;
        end
        if (en_col)
            result <= sum_d[2*WW +: TW];
    end
endmodule

// File: rtl/tex_filter_unit.sv
module tex_filter_unit #(
    parameter int LOG_W  = 8,
    parameter int LOG_H  = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [15:0]       req_u,
    input  logic [15:0]       req_v,
    input  logic [1:0]        req_mode_x,
    input  logic [1:0]        req_mode_y,
    input  logic              req_bilinear,
    input  logic              req_wide,
    input  logic [ADDR_W-1:0] req_base,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [15:0]       mem_rd_data,
    output logic              res_valid,
    output logic [15:0]       res_data
);
    import tex_pkg::*;
    localparam int CW    = COORD_W;
    localparam int TAPS  = 4;
    localparam int TAP_W = $clog2(TAPS);

    fsm_e state, state_nx;

    logic signed [16:0]    su, sv;
    logic signed [CW-1:0]  xc [2];
    logic signed [CW-1:0]  yc [2];
    logic [7:0]            xi [2];
    logic [7:0]            yi [2];
    logic [15:0]           code [TAPS];
    logic [ADDR_W-1:0]     addr_d [TAPS];

    logic [ADDR_W-1:0]     addr_q [TAPS];
    logic [TEXEL_W-1:0]    taps_q [TAPS];
    logic [WGT_W-1:0]      wx_q, wy_q;
    logic                  wide_q, single_q;
    logic [TAP_W-1:0]      tap_cnt, rd_idx_q;
    logic                  rd_pend_q;
    logic [TAP_W-1:0]      last_tap;

    // Tap coordinates: bilinear uses floor(c - 0.5) and its neighbour.
    always_comb begin
        su    = $signed({1'b0, req_u}) - 17'sd128;
        sv    = $signed({1'b0, req_v}) - 17'sd128;
        xc[0] = req_bilinear ? {su[16], su[16:8]} : {2'b00, req_u[15:8]};
        yc[0] = req_bilinear ? {sv[16], sv[16:8]} : {2'b00, req_v[15:8]};
        xc[1] = xc[0] + 10'sd1;
        yc[1] = yc[0] + 10'sd1;
    end

    for (genvar a = 0; a < 2; a++) begin : g_axis
        tex_bound #(.LOG_N(LOG_W), .CW(CW)) u_bx (
            .coord(xc[a]), .mode(req_mode_x), .idx(xi[a]));
        tex_bound #(.LOG_N(LOG_H), .CW(CW)) u_by (
            .coord(yc[a]), .mode(req_mode_y), .idx(yi[a]));
    end

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        tex_morton #(.IDX_W(8)) u_mort (
            .xi(xi[k % 2]), .yi(yi[k / 2]), .code(code[k]));
        assign addr_d[k] = req_base + ADDR_W'(code[k]);
    end

    assign last_tap  = single_q ? '0 : TAP_W'(TAPS - 1);
    assign req_ready = (state == ST_IDLE);
    assign mem_rd_en = (state == ST_READ);
    assign mem_addr  = addr_q[tap_cnt];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_valid) state_nx = ST_READ;
            ST_READ: if (tap_cnt == last_tap) state_nx = ST_WAIT;
            ST_WAIT: state_nx = ST_ROW;
            ST_ROW:  state_nx = ST_COL;
            ST_COL:  state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Outputs and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tap_cnt   <= '0;
            rd_idx_q  <= '0;
            rd_pend_q <= 1'b0;
            res_valid <= 1'b0;
            wx_q      <= '0;
            wy_q      <= '0;
            wide_q    <= 1'b0;
            single_q  <= 1'b0;
            for (int k = 0; k < TAPS; k++) begin
                addr_q[k] <= '0;
                taps_q[k] <= '0;
            end
        end else begin
            rd_pend_q <= mem_rd_en;
            rd_idx_q  <= tap_cnt;
            res_valid <= (state == ST_COL);
            if (state == ST_IDLE && req_valid) begin
                for (int k = 0; k < TAPS; k++) addr_q[k] <= addr_d[k];
                wx_q     <= req_bilinear ? su[7:0] : '0;
                wy_q     <= req_bilinear ? sv[7:0] : '0;
                wide_q   <= req_wide;
                single_q <= !req_bilinear;
                tap_cnt  <= '0;
            end else if (state == ST_READ && tap_cnt != last_tap) begin
                tap_cnt <= tap_cnt + 1'b1;
            end
            if (rd_pend_q)
                taps_q[rd_idx_q] <= wide_q ? mem_rd_data
                                           : {mem_rd_data[7:0], mem_rd_data[7:0]};
        end
    end

    tex_blend #(.TW(TEXEL_W), .WW(WGT_W)) u_blend (
        .clk    (clk),
        .en_row (state == ST_ROW),
        .en_col (state == ST_COL),
        .t00    (taps_q[0]),
        .t10    (taps_q[1]),
        .t01    (taps_q[2]),
        .t11    (taps_q[3]),
        .wx     (wx_q),
        .wy     (wy_q),
        .result (res_data)
    );
endmodule

// File: rtl/tex_filter_unit_chk.sv
module tex_filter_unit_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic req_bilinear,
    input logic mem_rd_en,
    input logic res_valid
);
    logic [2:0] rd_cnt;
    logic [2:0] since_rd;
    logic       bil_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_cnt   <= '0;
            since_rd <= 3'd7;
            bil_q    <= 1'b0;
        end else begin
            if (req_valid && req_ready) begin
                rd_cnt <= '0;
                bil_q  <= req_bilinear;
            end else if (mem_rd_en) begin
                rd_cnt <= rd_cnt + 3'd1;
            end
            if (mem_rd_en)          since_rd <= 3'd1;
            else if (since_rd != 7) since_rd <= since_rd + 3'd1;
        end
    end

    assert_no_read_when_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_rd_en);

    assert_ready_at_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> req_ready);

    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    assert_result_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> since_rd == 3'd4);

    // R6 covers the point-mode count of one
    assert_tap_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> rd_cnt == (bil_q ? 3'd4 : 3'd1));
endmodule

bind tex_filter_unit tex_filter_unit_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_bilinear (req_bilinear),
    .mem_rd_en    (mem_rd_en),
    .res_valid    (res_valid)
);

// File: tb/tex_filter_unit_tb.sv
`timescale 1ns/1ps
module tex_filter_unit_tb;
    localparam int LW = 3;
    localparam int LH = 2;
    localparam int NW = 1 << LW;
    localparam int NH = 1 << LH;
    localparam logic [15:0] BASE = 16'h1230;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_u = '0, req_v = '0;
    logic [1:0]  req_mode_x = '0, req_mode_y = '0;
    logic        req_bilinear = 1'b0, req_wide = 1'b0;
    logic        mem_rd_en;
    logic [15:0] mem_addr;
    logic [15:0] mem_rd_data = '0;
    logic        res_valid;
    logic [15:0] res_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    tex_filter_unit #(.LOG_W(LW), .LOG_H(LH), .ADDR_W(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_u(req_u), .req_v(req_v), .req_mode_x(req_mode_x), .req_mode_y(req_mode_y),
        .req_bilinear(req_bilinear), .req_wide(req_wide), .req_base(BASE),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_data(mem_rd_data),
        .res_valid(res_valid), .res_data(res_data));

    function automatic logic [15:0] mem_fn(input logic [15:0] a);
        int t;
        t = (int'(a) * 40503) ^ 23130;
        return t[15:0];
    endfunction

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (mem_rd_en) mem_rd_data <= mem_fn(mem_addr);
    end

    function automatic int resolve(input int c, input int n, input int mode);
        int p;
        if (mode == 1) return ((c % n) + n) % n;
        if (mode == 2) begin
            p = ((c % (2*n)) + 2*n) % (2*n);
            return (p < n) ? p : 2*n - 1 - p;
        end
        if (c < 0) return 0;
        if (c >= n) return n - 1;
        return c;
    endfunction

    function automatic logic [15:0] zaddr(input int x, input int y);
        int m = 0;
        for (int i = 0; i < 8; i++)
            m += (((x >> i) & 1) << (2*i)) + (((y >> i) & 1) << (2*i + 1));
        return 16'(int'(BASE) + m);
    endfunction

    function automatic longint norm(input logic [15:0] d, input bit wide);
        return wide ? longint'(d) : longint'(d[7:0]) * 257;
    endfunction

    function automatic string mtag(input int mx, input int my);
        if (mx == 2 || my == 2) return "R3";
        if (mx == 1 || my == 1) return "R2";
        return "R1";
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_req(input int u, input int v, input int mx, input int my,
                           input bit bil, input bit wide);
        logic [15:0] ea [4];
        logic [15:0] ga [4];
        int xs [2], ys [2];
        int nexp, nget, last_rd, su, sv, fx, fy;
        longint a, b, c, d, top, bot, expv;
        bit got;
        if (bil) begin
            su = u - 128; sv = v - 128;
            fx = su & 255; fy = sv & 255;
            xs[0] = resolve(su >>> 8, NW, mx); xs[1] = resolve((su >>> 8) + 1, NW, mx);
            ys[0] = resolve(sv >>> 8, NH, my); ys[1] = resolve((sv >>> 8) + 1, NH, my);
            for (int k = 0; k < 4; k++) ea[k] = zaddr(xs[k % 2], ys[k / 2]);
            a = norm(mem_fn(ea[0]), wide); b = norm(mem_fn(ea[1]), wide);
            c = norm(mem_fn(ea[2]), wide); d = norm(mem_fn(ea[3]), wide);
            top = a * (256 - fx) + b * fx;
            bot = c * (256 - fx) + d * fx;
            expv = (top * (256 - fy) + bot * fy) >> 16;
            nexp = 4;
        end else begin
            ea[0] = zaddr(resolve(u >> 8, NW, mx), resolve(v >> 8, NH, my));
            expv = norm(mem_fn(ea[0]), wide);
            nexp = 1;
        end
        @(negedge clk);
        req_u = 16'(u); req_v = 16'(v);
        req_mode_x = 2'(mx); req_mode_y = 2'(my);
        req_bilinear = bil; req_wide = wide; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        nget = 0; last_rd = -100; got = 0;
        for (int t = 0; t < 40 && !got; t++) begin
            if (mem_rd_en) begin
                if (nget < 4) ga[nget] = mem_addr;
                nget++; last_rd = t;
            end
            if (res_valid) begin
                got = 1;
                check(t - last_rd == 4, "R9 latency", t - last_rd, 4);
                check(res_data == 16'(expv),
                      $sformatf("%s %s%s value u=%0h v=%0h", mtag(mx, my),
                                bil ? "R7" : "R6", wide ? "" : " R8", u, v),
                      res_data, expv);
            end else begin
                @(negedge clk);
            end
        end
        check(got, "R9 no result", 0, 1);
        check(nget == nexp, bil ? "R5 read count" : "R6 read count", nget, nexp);
        for (int k = 0; k < nexp && k < nget; k++)
            check(ga[k] == ea[k], $sformatf("R4 %s R5 addr tap%0d u=%0h v=%0h",
                  mtag(mx, my), k, u, v), ga[k], ea[k]);
        @(negedge clk);
        check(res_valid == 1'b0, "R9 pulse width", res_valid, 0);
        check(req_ready == 1'b1, "R10 ready in idle", req_ready, 1);
    endtask

    initial begin
        int uvals [30];
        for (int i = 0; i < 10; i++) begin
            uvals[3*i]   = i * 256;
            uvals[3*i+1] = i * 256 + 128;
            uvals[3*i+2] = i * 256 + 240;
        end
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R10 reset ready", req_ready, 1);
        check(mem_rd_en == 1'b0, "R10 reset rd_en", mem_rd_en, 0);
        check(res_valid == 1'b0, "R10 reset valid", res_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // Directed corners: mirror of -1 and N, wrap of -1, clamp at far edge
        run_req(16'h0040, 16'h0040, 2, 2, 1, 1);
        run_req(16'h0840, 16'h0440, 2, 2, 1, 1);
        run_req(16'h0040, 16'h0040, 1, 1, 1, 0);
        run_req(16'hFFFF, 16'hFFFF, 0, 0, 1, 1);
        run_req(16'h0180, 16'h0180, 0, 0, 1, 1);
        for (int mx = 0; mx < 3; mx++)
            for (int my = 0; my < 3; my++)
                for (int f = 0; f < 4; f++)
                    for (int i = 0; i < 30; i++)
                        for (int j = 0; j < 30; j += 3)
                            run_req(uvals[i], uvals[(j + i) % 30], mx, my, f[0], f[1]);
        done = 1;
    end

    initial begin
        wait (done || cycles > 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule